// File: doc/BRIEF.md
# Serial Register Bank Slave with Auto-Increment

This block is a two-wire serial bus slave that gives a host access to a bank of 8-bit control registers. It samples the clock line (SCL) and data line (SDA) with the system clock, detects start and stop conditions and drives SDA only by pulling it low. A transfer opens with a byte that holds the 7-bit device address and a direction bit. On a write, the next byte selects the starting subaddress. Each following data byte goes to the next subaddress in turn.

A read first sets the subaddress with a short write. It then issues a repeated start and the address byte with the direction bit set to 1. The slave returns consecutive registers until the master declines a byte. Running past the top register is handled differently for each direction: reads keep returning the top register, while writes are refused and the slave returns to idle. Four consecutive registers hold a 32-bit frequency word. It reaches its live output only when all four bytes are written in order, in one auto-incrementing transfer, starting at the lowest byte.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The first byte after a start is acknowledged only when its upper seven bits equal the DEV_ADDR parameter. Bit 0 of that byte selects read (1) or write (0). Any other address is not acknowledged and the slave returns to idle.
- R2: In a write, the byte after the address sets the subaddress. Each acknowledged data byte is stored at the current subaddress, and the subaddress then advances by one.
- R3: A write of a single byte to any subaddress changes only that register. Every other register output keeps its value.
- R4: A subaddress of NREG or more is not acknowledged. The slave returns to idle, so no byte that follows in the same transfer is acknowledged or stored.
- R5: A data byte written when the subaddress has passed NREG-1 is not stored and not acknowledged. The slave returns to idle.
- R6: A read is set up by a write of address and subaddress, then a repeated start, then the address with bit 0 set. The slave then sends registers from the subaddress upward, most significant bit first, one register per byte the master acknowledges.
- R7: A read that runs past subaddress NREG-1 keeps returning the contents of register NREG-1.
- R8: When the master does not acknowledge a read byte (SDA high on the ninth clock), the read ends and the slave stops driving SDA.
- R9: A start or stop condition in the middle of a byte abandons the transfer at once. The partial byte is not stored. A start opens a new address phase.
- R10: Subaddresses FREQ_BASE to FREQ_BASE+3 hold the frequency bytes, with FREQ_BASE as bits 7:0 of the word. The live 32-bit word is loaded in one clock when byte FREQ_BASE+3 is written, and only if bytes FREQ_BASE to FREQ_BASE+2 were written in order earlier in the same transfer. Otherwise it keeps its value.
- R11: After reset, every register, the live frequency word and the SDA pull-down enable are 0.
- R12: SDA is driven only through an active-high pull-down enable. That enable is clear whenever the slave is idle and is raised only after a detected SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the pad |
| sda_in | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | Pull SDA low when 1; release it when 0 |
| regs_flat | output | NREG*8 | All register contents; register i sits in bits 8*i+7 to 8*i |
| freq_word | output | 32 | Committed 32-bit frequency word |

## Verification
Some rules are checked on every cycle: no register changes without an internal write strobe, and that strobe never targets an address beyond the bank. The live frequency word changes only just after a write to its top byte. A stop always leaves the slave idle, and the pull-down is never active while the slave is idle and only rises after an SCL fall. Other behaviour shows only in the bench's bus scenarios: which bytes are acknowledged, the order of the bytes read back, the repeated top register, the in-order rule for committing the frequency word, and aborts in the middle of a byte. The bench sweeps every subaddress for single writes and every start point around the frequency group.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_RX,
        LS_RXACK,
        LS_TX,
        LS_TXACK
    } link_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_SUB,
        PH_DATA
    } rx_phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    localparam int unsigned BYTE_BITS = 8;

    function automatic logic addr_in_bank(input logic [7:0] a, input int unsigned n);
        return 32'(a) < n;
    endfunction

endpackage

// File: rtl/rbs_line_sync.sv
module rbs_line_sync
    import rbs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/rbs_link_fsm.sv
module rbs_link_fsm
    import rbs_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h2C,
    parameter int unsigned NREG     = 26
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe,
    output logic       busy,
    output logic       seq_clr
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);
    localparam logic [7:0] TOP_ADDR = 8'(NREG - 1);

    link_state_t st;
    rx_phase_t   ph;
    logic [3:0]  bitcnt;
    logic [7:0]  rx_sh;
    logic [7:0]  tx_sh;
    logic [7:0]  ptr;
    logic        rw;
    logic        mack;

    assign rd_addr = ptr;
    assign busy    = (st != LS_IDLE);
    assign seq_clr = evt.start | evt.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= LS_IDLE;
            ph      <= PH_ADDR;
            bitcnt  <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.stop) begin
                st     <= LS_IDLE;
                sda_oe <= 1'b0;
            end else if (evt.start) begin
                st     <= LS_RX;
                ph     <= PH_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    LS_RX: begin
                        if (evt.scl_rise) begin
                            rx_sh  <= {rx_sh[6:0], evt.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (evt.scl_fall && bitcnt == LAST_BIT) begin
                            case (ph)
                                PH_ADDR: begin
                                    if (rx_sh[7:1] == DEV_ADDR) begin
                                        rw     <= rx_sh[0];
                                        sda_oe <= 1'b1;
                                        st     <= LS_RXACK;
                                        if (!rx_sh[0]) ph <= PH_SUB;
                                    end else begin
                                        st <= LS_IDLE;
                                    end
                                end
                                PH_SUB: begin
                                    if (addr_in_bank(rx_sh, NREG)) begin
                                        ptr    <= rx_sh;
                                        sda_oe <= 1'b1;
                                        st     <= LS_RXACK;
                                        ph     <= PH_DATA;
                                    end else begin
                                        st <= LS_IDLE;
                                    end
                                end
                                default: begin
                                    if (addr_in_bank(ptr, NREG)) begin
                                        wr_en   <= 1'b1;
                                        wr_addr <= ptr;
                                        wr_data <= rx_sh;
                                        ptr     <= ptr + 8'd1;
                                        sda_oe  <= 1'b1;
                                        st      <= LS_RXACK;
                                    end else begin
                                        st <= LS_IDLE;
                                    end
                                end
                            endcase
                        end
                    end
                    LS_RXACK: begin
                        if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                st     <= LS_TX;
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                st     <= LS_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    LS_TX: begin
                        if (evt.scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (evt.scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                st     <= LS_TXACK;
                            end else begin
                                sda_oe <= ~tx_sh[6];
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                            end
                        end
                    end
                    LS_TXACK: begin
                        if (evt.scl_rise) begin
                            mack <= ~evt.sda;
                            if (!evt.sda && ptr < TOP_ADDR) ptr <= ptr + 8'd1;
                        end else if (evt.scl_fall) begin
                            if (mack) begin
                                st     <= LS_TX;
                                bitcnt <= '0;
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                st <= LS_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/rbs_reg_file.sv
module rbs_reg_file
    import rbs_pkg::*;
#(
    parameter int unsigned NREG      = 26,
    parameter int unsigned FREQ_BASE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_addr,
    input  logic              seq_clr,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_flat,
    output logic [31:0]       freq_word
);
    localparam int unsigned IW     = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [7:0]  F0     = 8'(FREQ_BASE);
    localparam logic [7:0]  F1     = 8'(FREQ_BASE + 1);
    localparam logic [7:0]  F2     = 8'(FREQ_BASE + 2);
    localparam logic [7:0]  F3     = 8'(FREQ_BASE + 3);

    logic [7:0] regs [NREG];
    logic [1:0] seq_cnt;
    logic       seq_full;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) regs[i] <= '0;
            else if (wr_en && wr_addr == 8'(i)) regs[i] <= wr_data;
        end
        assign regs_flat[i*8 +: 8] = regs[i];
    end

    always_comb begin
        if (32'(rd_addr) >= NREG) rd_data = regs[NREG-1];
        else                      rd_data = regs[rd_addr[IW-1:0]];
    end

    // seq_cnt/seq_full track how many frequency bytes arrived in order
    always_ff @(posedge clk) begin
        if (rst) begin
            seq_cnt   <= '0;
            seq_full  <= 1'b0;
            freq_word <= '0;
        end else if (seq_clr) begin
            seq_cnt  <= '0;
            seq_full <= 1'b0;
        end else if (wr_en) begin
            seq_cnt  <= '0;
            seq_full <= 1'b0;
            if (wr_addr == F0) begin
                seq_cnt <= 2'd1;
            end else if (wr_addr == F1 && seq_cnt == 2'd1) begin
                seq_cnt <= 2'd2;
            end else if (wr_addr == F2 && seq_cnt == 2'd2) begin
                seq_full <= 1'b1;
            end else if (wr_addr == F3 && seq_full) begin
                freq_word <= {wr_data, regs[FREQ_BASE+2], regs[FREQ_BASE+1], regs[FREQ_BASE]};
            end
        end
    end

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import rbs_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h2C,
    parameter int unsigned NREG        = 26,
    parameter int unsigned FREQ_BASE   = 2,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [NREG*8-1:0] regs_flat,
    output logic [31:0]       freq_word
);
    bus_evt_t   evt;
    logic [7:0] rd_data;
    logic [7:0] rd_addr;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic       busy;
    logic       seq_clr;
    logic       stop_seen;
    logic       fall_seen;

    assign stop_seen = evt.stop;
    assign fall_seen = evt.scl_fall;

    rbs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    rbs_link_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sda_oe  (sda_oe),
        .busy    (busy),
        .seq_clr (seq_clr)
    );

    rbs_reg_file #(.NREG(NREG), .FREQ_BASE(FREQ_BASE)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .seq_clr   (seq_clr),
        .rd_data   (rd_data),
        .regs_flat (regs_flat),
        .freq_word (freq_word)
    );

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
    parameter int unsigned NREG      = 26,
    parameter int unsigned FREQ_BASE = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [7:0]        wr_addr,
    input logic [NREG*8-1:0] regs_flat,
    input logic [31:0]       freq_word,
    input logic              sda_oe,
    input logic              busy,
    input logic              stop_seen,
    input logic              fall_seen
);
    // R3: register outputs move only after a write strobe
    a_r3_quiet_without_write: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(regs_flat));

    // R5: the write strobe never targets an address outside the bank
    a_r5_write_in_bank: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (32'(wr_addr) < NREG));

    // R10: the live word changes only right after a write to the top frequency byte
    a_r10_commit_on_top_byte: assert property (@(posedge clk) disable iff (rst)
        !$stable(freq_word) |-> ($past(wr_en) && $past(wr_addr) == 8'(FREQ_BASE + 3)));

    // R9: a stop condition always leaves the slave idle
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !busy);

    // R12: pull-down released while idle
    a_r12_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sda_oe);

    // R12: pull-down only starts after a detected SCL fall
    a_r12_drive_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(fall_seen));

endmodule

bind i2c_regbank_slave rbs_checker #(.NREG(NREG), .FREQ_BASE(FREQ_BASE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .regs_flat (regs_flat),
    .freq_word (freq_word),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .stop_seen (stop_seen),
    .fall_seen (fall_seen)
);

// File: tb/i2c_regbank_slave_test.sv
module i2c_regbank_slave_test;
    localparam int         NREG = 26;
    localparam int         FB   = 2;
    localparam logic [6:0] DEV  = 7'h2C;
    localparam int         Q    = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              m_scl = 1'b1;
    logic              m_sda = 1'b1;
    logic              bus_sda;
    logic              sda_oe;
    logic [NREG*8-1:0] regs_flat;
    logic [31:0]       freq_word;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0]  model [NREG];
    logic [31:0] mfreq;
    logic [7:0]  wbuf [64];
    logic [7:0]  rbuf [64];
    logic [63:0] acks;

    assign bus_sda = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    i2c_regbank_slave #(.DEV_ADDR(DEV), .NREG(NREG), .FREQ_BASE(FB)) uut (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (m_scl),
        .sda_in    (bus_sda),
        .sda_oe    (sda_oe),
        .regs_flat (regs_flat),
        .freq_word (freq_word)
    );

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary_and_end();
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        int bad = -1;
        for (int i = 0; i < NREG; i++)
            if (bad < 0 && regs_flat[i*8 +: 8] !== model[i]) bad = i;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, 64'(regs_flat[bad*8 +: 8]), 64'(model[bad]));
        chk(freq_word === mfreq, "R10", 64'(freq_word), 64'(mfreq));
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0;
    endtask

    task automatic i2c_stop();
        wq(); m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        wq(); m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); ack = ~bus_sda; wq(); m_scl = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        m_sda = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            wq(); wq(); m_scl = 1'b1; wq(); d = {d[6:0], bus_sda}; wq(); m_scl = 1'b0;
        end
        wq(); m_sda = ~mack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0;
        m_sda = 1'b1;
    endtask

    // write n bytes of wbuf starting at sub; acks bit0=address, bit1=sub, bit2+k=data k
    task automatic do_write(input logic [7:0] sub, input int n);
        logic a;
        acks = '0;
        i2c_start();
        send_byte({DEV, 1'b0}, a); acks[0] = a;
        send_byte(sub, a); acks[1] = a;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a); acks[2+k] = a;
        end
        i2c_stop();
    endtask

    function automatic logic [63:0] exp_acks(input int sub, input int n);
        logic [63:0] e = 64'd1;
        if (sub < NREG) begin
            e[1] = 1'b1;
            for (int k = 0; k < n; k++) e[2+k] = (sub + k < NREG);
        end
        return e;
    endfunction

    task automatic apply_model(input int sub, input int n);
        int stored = 0;
        if (sub < NREG) begin
            for (int k = 0; k < n; k++)
                if (sub + k < NREG) begin
                    model[sub+k] = wbuf[k];
                    stored++;
                end
        end
        if (stored > 0 && sub <= FB && sub + stored - 1 >= FB + 3)
            mfreq = {model[FB+3], model[FB+2], model[FB+1], model[FB]};
    endtask

    task automatic write_and_check(input int sub, input int n, input string req);
        do_write(8'(sub), n);
        chk(acks === exp_acks(sub, n), req, acks, exp_acks(sub, n));
        apply_model(sub, n);
        chk_regs(req);
    endtask

    task automatic do_read(input int sub, input int n, input string req);
        logic a;
        logic [7:0] e;
        i2c_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'(sub), a);
        i2c_start();
        send_byte({DEV, 1'b1}, a);
        chk(a === 1'b1, "R6", 64'(a), 64'd1);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        wq();
        chk(sda_oe === 1'b0, "R8", 64'(sda_oe), 64'd0);
        i2c_stop();
        for (int k = 0; k < n; k++) begin
            e = (sub + k < NREG) ? model[sub+k] : model[NREG-1];
            chk(rbuf[k] === e, req, 64'(rbuf[k]), 64'(e));
        end
    endtask

    initial begin
        logic a;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        mfreq = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R11: reset state
        chk(sda_oe === 1'b0, "R11", 64'(sda_oe), 64'd0);
        chk_regs("R11");

        // R1: wrong address refused for both directions, right address accepted
        i2c_start(); send_byte({DEV ^ 7'h01, 1'b0}, a); i2c_stop();
        chk(a === 1'b0, "R1", 64'(a), 64'd0);
        i2c_start(); send_byte({DEV ^ 7'h40, 1'b1}, a); i2c_stop();
        chk(a === 1'b0, "R1", 64'(a), 64'd0);
        i2c_start(); send_byte({DEV, 1'b0}, a); i2c_stop();
        chk(a === 1'b1, "R1", 64'(a), 64'd1);
        chk(sda_oe === 1'b0, "R12", 64'(sda_oe), 64'd0);

        // R2: burst over the whole bank from subaddress 0 (commits the word, R10)
        for (int k = 0; k < NREG; k++) wbuf[k] = 8'((k * 7 + 3) & 255);
        write_and_check(0, NREG, "R2");

        // R5: burst running past the top register
        for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'hC0 + k);
        write_and_check(NREG - 2, 4, "R5");

        // R3: single-byte write at every subaddress
        for (int s = 0; s < NREG; s++) begin
            wbuf[0] = 8'((s * 37 + 8'h5A) & 255);
            write_and_check(s, 1, "R3");
        end

        // R10: four-byte bursts from every start around the frequency group
        for (int s = 0; s <= FB + 3; s++) begin
            for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'h80 + 16 * s + k);
            write_and_check(s, 4, "R10");
        end

        // R4: invalid subaddresses, followed by a data byte
        wbuf[0] = 8'hEE;
        write_and_check(NREG, 1, "R4");
        write_and_check(8'h80, 1, "R4");
        write_and_check(8'hFF, 1, "R4");

        // R6: read the whole bank back
        do_read(0, NREG, "R6");

        // R7: read past the top register
        do_read(NREG - 4, 9, "R7");

        // R9: stop in the middle of a data byte
        i2c_start(); send_byte({DEV, 1'b0}, a); send_byte(8'd9, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        i2c_stop();
        chk_regs("R9");
        chk(sda_oe === 1'b0, "R12", 64'(sda_oe), 64'd0);

        // R9: start in the middle of a byte opens a fresh address phase
        i2c_start(); send_byte({DEV, 1'b0}, a); send_byte(8'd9, a);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        i2c_start();
        send_byte({DEV, 1'b0}, a);
        chk(a === 1'b1, "R9", 64'(a), 64'd1);
        send_byte(8'd10, a);
        send_byte(8'h3C, a);
        i2c_stop();
        model[10] = 8'h3C;
        chk_regs("R9");

        summary_and_end();
    end

endmodule